// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Generator and Checker

This block keeps a 16-bit cyclic redundancy remainder for the generator x^16 + x^12 + x^5 + 1 and advances it by a whole byte on every enabled clock. The result is the same as eight steps of a one-bit shift register, but it is computed in one cycle by an XOR network. Before a frame, a synchronous clear sets the remainder to zero. To resume a frame that was cut into pieces, a load port writes an interim remainder into the register.

When transmitting, the host feeds the payload bytes one per enabled cycle and then pulses an end-of-payload strobe. The block then puts the two remainder bytes on its byte output over two consecutive cycles, with a valid flag on each. When receiving, the payload and the two appended bytes all go through the same engine. A zero-remainder flag shows whether the frame arrived intact.

Top module: `crc16_byte_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, the remainder is 0x0000, the append valid output is low and the zero flag is high.
- R2: Each enabled cycle gives the remainder that eight serial steps would give. In each step, data bit i is handled in the order bit 0 first. Feedback = remainder bit 0 XOR the data bit. The remainder shifts right by one. When feedback is 1, the remainder is XORed with 0x8408.
- R3: Clear forces the remainder to zero on the next edge. Clear wins over load and over enable.
- R4: Load writes the 16-bit load value into the remainder on the next edge. Load wins over enable.
- R5: When clear, load and enable are all low, the remainder holds its value whatever the data input carries.
- R6: An end-of-payload strobe accepted while idle raises byte-valid for exactly the two following cycles. The byte output carries remainder bits [7:0] in the first of those cycles and bits [15:8] in the second, both taken from the remainder as it stood in the strobe cycle.
- R7: In the strobe cycle and in both append cycles, enable has no effect on the remainder.
- R8: A strobe that arrives while the two append cycles are in progress is ignored, so valid stays high for no more than two cycles in a row.
- R9: The zero flag is high exactly when the remainder is zero. This is the case after a cleared engine has taken a payload followed by its low and then its high remainder byte.
- R10: If any bit of the appended remainder is flipped before it is checked, the zero flag ends low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Zero the remainder (highest priority) |
| load_i | input | 1 | Preload the remainder from load_val_i |
| load_val_i | input | 16 | Interim remainder to preload |
| en_i | input | 1 | Absorb data_i this cycle |
| data_i | input | 8 | Input byte, bit 0 absorbed first |
| eop_i | input | 1 | End-of-payload strobe, starts the append |
| tx_byte_o | output | 8 | Appended remainder byte |
| tx_valid_o | output | 1 | tx_byte_o carries an append byte |
| crc_o | output | 16 | Current remainder |
| zero_o | output | 1 | Remainder equals zero |

## Verification
The hardest state to reach is overlapping control: an enable or a second strobe that arrives while the append is running, and a clear or load that arrives in the same cycle as the strobe. The stimulus raises enable with random data through the strobe cycle and both append cycles. It also repeats the strobe inside the append window, and it drives clear, load and enable together so that both priority chains are exercised. Frames that are closed by their own remainder, and copies with one flipped bit, check the zero flag on the receive side against a serial reference.

// File: rtl/crc16_byte_pkg.sv
package crc16_byte_pkg;
  typedef enum logic [1:0] {
    APP_IDLE = 2'd0,
    APP_LO   = 2'd1,
    APP_HI   = 2'd2
  } app_state_e;

  localparam int unsigned CRC_W_DEF  = 16;
  localparam int unsigned DATA_W_DEF = 8;
  localparam logic [15:0] POLY_REFL_DEF = 16'h8408;
endpackage

// File: rtl/crc16_next_net.sv
module crc16_next_net #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 16'h8408
) (
  input  logic [CRC_W-1:0]  cur_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  nxt_o
);
  localparam bit FAST = (CRC_W == 16) && (DATA_W == 8) && (POLY_REFL == 16'h8408);

  generate
    if (FAST) begin : g_closed
      // mix terms: register low byte against the incoming byte
      logic [7:0] mix;
      logic [7:0] fold;
      assign mix  = cur_i[7:0] ^ data_i;
      assign fold = mix ^ {mix[3:0], 4'b0000};
      assign nxt_o = {8'h00, cur_i[15:8]}
                   ^ {fold, 8'h00}
                   ^ {5'b00000, fold, 3'b000}
                   ^ {12'h000, fold[7:4]};
    end else begin : g_unrolled
      always_comb begin
        logic [CRC_W-1:0] v;
        logic fb;
        v = cur_i;
        for (int i = 0; i < DATA_W; i++) begin
          fb = v[0] ^ data_i[i];
          v  = v >> 1;
          if (fb) v = v ^ POLY_REFL;
        end
        nxt_o = v;
      end
    end
  endgenerate
endmodule

// File: rtl/crc16_state_reg.sv
module crc16_state_reg #(
  parameter int unsigned CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CRC_W-1:0] load_val_i,
  input  logic             adv_i,
  input  logic [CRC_W-1:0] nxt_i,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (rst || clr_i)   crc_q <= '0;
    else if (load_i)    crc_q <= load_val_i;
    else if (adv_i)     crc_q <= nxt_i;
  end
endmodule

// File: rtl/crc16_append_seq.sv
module crc16_append_seq
  import crc16_byte_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eop_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              freeze_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_valid_o
);
  app_state_e        st_q;
  logic [DATA_W-1:0] hi_q;
  logic              start;

  assign start    = eop_i && (st_q == APP_IDLE);
  assign freeze_o = start || (st_q != APP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= APP_IDLE;
      tx_byte_o  <= '0;
      tx_valid_o <= 1'b0;
      hi_q       <= '0;
    end else begin
      case (st_q)
        APP_IDLE: begin
          if (start) begin
            st_q       <= APP_LO;
            tx_byte_o  <= crc_i[DATA_W-1:0];
            hi_q       <= crc_i[2*DATA_W-1:DATA_W];
            tx_valid_o <= 1'b1;
          end
        end
        APP_LO: begin
          st_q       <= APP_HI;
          tx_byte_o  <= hi_q;
          tx_valid_o <= 1'b1;
        end
        default: begin
          st_q       <= APP_IDLE;
          tx_valid_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
  import crc16_byte_pkg::*;
#(
  parameter int unsigned CRC_W  = CRC_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY_REFL = POLY_REFL_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [CRC_W-1:0]  load_val_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              eop_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_valid_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              zero_o
);
  logic [CRC_W-1:0] nxt;
  logic             freeze;

  crc16_next_net #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY_REFL(POLY_REFL)) u_net (
    .cur_i (crc_o),
    .data_i(data_i),
    .nxt_o (nxt)
  );

  crc16_state_reg #(.CRC_W(CRC_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .adv_i     (en_i && !freeze),
    .nxt_i     (nxt),
    .crc_q     (crc_o)
  );

  crc16_append_seq #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .eop_i     (eop_i),
    .crc_i     (crc_o),
    .freeze_o  (freeze),
    .tx_byte_o (tx_byte_o),
    .tx_valid_o(tx_valid_o)
  );

  assign zero_o = (crc_o == '0);
endmodule

// File: rtl/crc16_byte_chk.sv
module crc16_byte_chk #(
  parameter int unsigned CRC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             load_i,
  input logic [CRC_W-1:0] load_val_i,
  input logic             en_i,
  input logic             tx_valid_o,
  input logic [CRC_W-1:0] crc_o
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (crc_o == '0 && !tx_valid_o));

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_o == '0));

  assert_load_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clr_i) |=> (crc_o == $past(load_val_i)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !en_i) |=> $stable(crc_o));

  assert_pair_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid_o) |=> tx_valid_o);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !clr_i && !load_i) |=> $stable(crc_o));

  assert_max_two_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && $past(tx_valid_o)) |=> !tx_valid_o);
endmodule

bind crc16_byte_engine crc16_byte_chk #(.CRC_W(CRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_i     (clr_i),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .en_i      (en_i),
  .tx_valid_o(tx_valid_o),
  .crc_o     (crc_o)
);

// File: tb/crc16_byte_engine_test.sv
module crc16_byte_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_i = 1'b0, load_i = 1'b0, en_i = 1'b0, eop_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  tx_byte_o;
  logic        tx_valid_o;
  logic [15:0] crc_o;
  logic        zero_o;

  always #2 clk = ~clk;

  crc16_byte_engine uut (
    .clk(clk), .rst(rst), .clr_i(clr_i), .load_i(load_i), .load_val_i(load_val_i),
    .en_i(en_i), .data_i(data_i), .eop_i(eop_i), .tx_byte_o(tx_byte_o),
    .tx_valid_o(tx_valid_o), .crc_o(crc_o), .zero_o(zero_o)
  );

  typedef struct {
    int          kind;   // 0 remainder, 1 append output, 2 zero flag
    logic [15:0] exp;
    logic        vexp;
    string       req;
  } item_t;

  item_t q[$];
  int runs = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_crc = '0;
  int          m_st = 0;
  logic [7:0]  m_hi = '0;

  function automatic logic [15:0] ser(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      runs++;
      case (it.kind)
        0: if (crc_o !== it.exp) begin
             fails++; $display("FAIL %s remainder: actual %h expected %h", it.req, crc_o, it.exp);
           end
        1: if (tx_valid_o !== it.vexp || (it.vexp && tx_byte_o !== it.exp[7:0])) begin
             fails++; $display("FAIL %s append: actual v=%b b=%h expected v=%b b=%h",
                               it.req, tx_valid_o, tx_byte_o, it.vexp, it.exp[7:0]);
           end
        default: if (zero_o !== it.vexp) begin
             fails++; $display("FAIL %s zero flag: actual %b expected %b", it.req, zero_o, it.vexp);
           end
      endcase
    end
  end

  task automatic push(input int k, input logic [15:0] e, input logic v, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.vexp = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic step(input logic c, input logic l, input logic [15:0] lv, input logic e,
                      input logic [7:0] d, input logic p, input string r);
    logic frz;
    logic [7:0] tb;
    @(negedge clk);
    clr_i = c; load_i = l; load_val_i = lv; en_i = e; data_i = d; eop_i = p;
    @(posedge clk);
    frz = (p && m_st == 0) || (m_st != 0);
    tb = 8'h00;
    if (m_st == 0 && p) begin m_st = 1; tb = m_crc[7:0]; m_hi = m_crc[15:8]; end
    else if (m_st == 1) begin m_st = 2; tb = m_hi; end
    else if (m_st == 2) m_st = 0;
    if (c) m_crc = '0;
    else if (l) m_crc = lv;
    else if (e && !frz) m_crc = ser(m_crc, d);
    push(0, m_crc, 1'b0, r);
    push(1, {8'h00, tb}, m_st != 0, r);
  endtask

  task automatic quiet(input string r);
    step(0, 0, 16'h0, 0, 8'h00, 0, r);
  endtask

  task automatic send(input logic [7:0] d, input string r);
    step(0, 0, 16'h0, 1, d, 0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    logic [7:0]  lo, hi;
    repeat (3) @(posedge clk);
    push(0, 16'h0, 0, "R1"); push(1, 16'h0, 0, "R1"); push(2, 16'h0, 1, "R1");
    @(negedge clk); rst = 0;
    @(posedge clk);
    push(0, 16'h0, 0, "R1"); push(1, 16'h0, 0, "R1"); push(2, 16'h0, 1, "R1");

    // R2: several byte patterns against the serial reference
    for (int f = 0; f < 4; f++) begin
      step(1, 0, 16'h0, 0, 8'h00, 0, "R2");
      for (int i = 0; i < 40; i++) begin
        logic [7:0] b;
        b = (f == 0) ? 8'h00 : (f == 1) ? 8'hFF : (f == 2) ? 8'(i) : 8'($urandom);
        send(b, "R2");
      end
    end
    step(0, 1, 16'hFFFF, 0, 8'h00, 0, "R4");
    send(8'h31, "R2"); send(8'h32, "R2"); send(8'h33, "R2");

    // R5: enable low, data toggles
    for (int i = 0; i < 6; i++) step(0, 0, 16'h0, 0, 8'($urandom), 0, "R5");

    // R3 / R4 priority
    step(1, 1, 16'hA5A5, 1, 8'h5A, 0, "R3");
    step(0, 1, 16'h1D0F, 1, 8'h77, 0, "R4");
    send(8'h12, "R2");
    step(1, 0, 16'h0, 1, 8'hEE, 0, "R3");

    // R6 / R7 / R8: append with enable held and repeated strobes
    for (int i = 0; i < 5; i++) send(8'($urandom), "R2");
    step(0, 0, 16'h0, 1, 8'hC3, 1, "R7");
    step(0, 0, 16'h0, 1, 8'h3C, 1, "R8");
    step(0, 0, 16'h0, 1, 8'h99, 1, "R8");
    step(0, 0, 16'h0, 0, 8'h00, 0, "R6");
    quiet("R6");
    step(0, 0, 16'h0, 0, 8'h00, 1, "R6");
    step(1, 0, 16'h0, 0, 8'h00, 0, "R6");
    step(0, 0, 16'h0, 1, 8'h44, 0, "R7");
    quiet("R6");

    // R9 / R10: close frames with their own remainder
    for (int f = 0; f < 6; f++) begin
      step(1, 0, 16'h0, 0, 8'h00, 0, "R9");
      for (int i = 0; i < 8 + f; i++) send(8'($urandom), "R9");
      snap = m_crc; lo = snap[7:0]; hi = snap[15:8];
      if (f >= 3) hi = hi ^ (8'h01 << f);
      send(lo, (f >= 3) ? "R10" : "R9");
      send(hi, (f >= 3) ? "R10" : "R9");
      if (f >= 3) push(2, 16'h0, 0, "R10");
      else        push(2, 16'h0, 1, "R9");
    end
    quiet("R5");
    push(2, 16'h0, (m_crc == 16'h0), "R9");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule